// File: doc/BRIEF.md
# SECDED Hamming Encoder

This block turns a K-bit data word into an extended Hamming code word that a later decoder can use to correct any single flipped bit and to detect any two flipped bits. The word is made of the K data bits, a set of Hamming check bits and one bit of overall parity. The block is purely combinational, with no clock and no state. It sits in a write path just before a word is stored or sent.

A parameter puts the overall parity bit at either end of the packed word. The check-bit vector and the overall parity bit also drive their own outputs, so a user can log or route them without unpacking the code word. The number of check bits is worked out from K when the design is elaborated.

Top module: `secded_encoder`

## Requirements
- R1: The check-bit count CHK_W is the smallest value of at least 1 with 2^CHK_W ≥ CHK_W + K + 1. The code word is K + CHK_W + 1 bits wide, so the default K = 8 gives 4 check bits and a 13-bit word.
- R2: Number the Hamming part of the word by positions 1 to K + CHK_W. Check bit j, driven on check_o[j], makes the parity even over all positions whose index has bit j set.
- R3: Data bits fill the positions that are not powers of two, in ascending order. data_i[0] goes to position 3, and for K = 8 data_i[7] goes to position 12.
- R4: Check bit j sits at Hamming position 2^j.
- R5: overall_o makes the parity of the whole code word even.
- R6: With P0_AT_LSB = 0, overall parity is the top bit of code_o, and Hamming position i is code_o bit i-1.
- R7: With P0_AT_LSB = 1, overall parity is code_o bit 0, and Hamming position i is code_o bit i.
- R8: check_o and overall_o hold the same values as the matching bits inside code_o.
- R9: An all-zero data word gives an all-zero code word, all-zero check bits and zero overall parity.
- R10: The outputs follow a change of data_i with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | K | Data word to encode |
| code_o | output | K+CHK_W+1 | Packed code word |
| check_o | output | CHK_W | Hamming check bits, bit j covers index bit j |
| overall_o | output | 1 | Overall even-parity bit |

## Verification
The block holds no state, so any fault shows on the ports in the same evaluation as the input that exposes it. A wrong data placement or a wrong check mask appears as a nonzero syndrome of code_o, or as a mismatch against the expected word, for some single-bit data pattern. A misplaced parity bit flips the total parity of code_o. A swapped packing shows up right away on the LSB and MSB variants, which are driven with the same data.

// File: rtl/secded_pkg.sv
// Package: elaboration-time helpers for the SECDED encoder.
// Assumes: every argument is a small positive constant known at elaboration.
package secded_pkg;

    // Smallest check-bit count that covers k data bits plus the check bits themselves.
    function automatic int check_count(input int k);
        int m;
        m = 1;
        while ((1 << m) < (m + k + 1)) m = m + 1;
        return m;
    endfunction

    // True when p is a power of two (the position of a check bit).
    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Hamming position of data bit idx: the (idx+1)-th position that is not a power of two.
    function automatic int data_pos(input int idx);
        int pos;
        int cnt;
        pos = 0;
        cnt = -1;
        while (cnt < idx) begin
            pos = pos + 1;
            if (!is_pow2(pos)) cnt = cnt + 1;
        end
        return pos;
    endfunction

endpackage

// File: rtl/secded_scatter.sv
// Module: secded_scatter
// Spreads the data bits over the non-power-of-two Hamming positions, in
// ascending order, and leaves zeros at the check-bit positions.
// Assumes: N equals K plus the check-bit count for K.
module secded_scatter #(
    parameter int K = 8,
    parameter int N = 12
) (
    input  logic [K-1:0] data_i,
    output logic [N:1]   ham_o
);

    localparam int CHK_W = N - K;

    // Data bits go to their computed positions.
    for (genvar b = 0; b < K; b++) begin : g_data
        localparam int POS = secded_pkg::data_pos(b);
        assign ham_o[POS] = data_i[b];
    end

    // Check positions stay zero so that the check generator sees only data.
    for (genvar j = 0; j < CHK_W; j++) begin : g_hole
        assign ham_o[1 << j] = 1'b0;
    end

endmodule

// File: rtl/secded_checkgen.sv
// Module: secded_checkgen
// Builds one even-parity check bit per index bit j over every Hamming position
// whose index has bit j set.
// Assumes: the check positions of ham_i are zero, or hold the check bits
// themselves (then the result is the syndrome).
module secded_checkgen #(
    parameter int N     = 12,
    parameter int CHK_W = 4
) (
    input  logic [N:1]       ham_i,
    output logic [CHK_W-1:0] check_o
);

    logic [CHK_W-1:0][N:1] terms;

    for (genvar j = 0; j < CHK_W; j++) begin : g_chk
        // Select the positions covered by check bit j.
        for (genvar i = 1; i <= N; i++) begin : g_pos
            if (((i >> j) & 1) == 1) begin : g_on
                assign terms[j][i] = ham_i[i];
            end else begin : g_off
                assign terms[j][i] = 1'b0;
            end
        end
        // Reduce the selected positions to a parity bit.
        assign check_o[j] = ^terms[j];
    end

endmodule

// File: rtl/secded_parity.sv
// Module: secded_parity
// Even-parity bit over a vector of any width.
// Assumes: W is at least 1.
module secded_parity #(
    parameter int W = 12
) (
    input  logic [W-1:0] vec_i,
    output logic         par_o
);

    // XOR reduction gives the bit that makes the total even.
    assign par_o = ^vec_i;

endmodule

// File: rtl/secded_encoder.sv
// Module: secded_encoder (top)
// Combinational SECDED encoder: data bits, Hamming check bits at power-of-two
// positions, and one overall parity bit placed at the MSB (P0_AT_LSB = 0) or
// at the LSB (P0_AT_LSB = 1) of the packed word.
// Assumes: K >= 1; there is no clock, so the outputs follow data_i directly.
module secded_encoder #(
    parameter int  K         = 8,
    parameter bit  P0_AT_LSB = 1'b0,
    localparam int CHK_W     = secded_pkg::check_count(K),
    localparam int W         = K + CHK_W + 1
) (
    input  logic [K-1:0]     data_i,
    output logic [W-1:0]     code_o,
    output logic [CHK_W-1:0] check_o,
    output logic             overall_o
);

    localparam int N = K + CHK_W;

    logic [N:1]       ham_data;
    logic [N:1]       ham_full;
    logic [CHK_W-1:0] chk;
    logic [CHK_W-1:0] synd;
    logic             p0;

    secded_scatter #(.K(K), .N(N)) u_scatter (
        .data_i (data_i),
        .ham_o  (ham_data)
    );

    secded_checkgen #(.N(N), .CHK_W(CHK_W)) u_checkgen (
        .ham_i   (ham_data),
        .check_o (chk)
    );

    // Insert the check bits at their power-of-two positions.
    for (genvar i = 1; i <= N; i++) begin : g_full
        if (secded_pkg::is_pow2(i)) begin : g_chk
            assign ham_full[i] = chk[$clog2(i)];
        end else begin : g_dat
            assign ham_full[i] = ham_data[i];
        end
    end

    secded_parity #(.W(N)) u_parity (
        .vec_i (ham_full),
        .par_o (p0)
    );

    // Pack the word with the overall parity bit at the chosen end.
    if (P0_AT_LSB) begin : g_lsb
        assign code_o = {ham_full, p0};
    end else begin : g_msb
        assign code_o = {p0, ham_full};
    end

    assign check_o   = chk;
    assign overall_o = p0;

    // Recompute the checks over the finished word to guard the assembly.
    secded_checkgen #(.N(N), .CHK_W(CHK_W)) u_synd (
        .ham_i   (ham_full),
        .check_o (synd)
    );

    // Check the assembled word against its own syndrome and parity.
    always_comb begin
        // R2
        zero_syndrome_chk: assert (synd == '0);
        // R5
        even_word_chk: assert ((^code_o) == 1'b0);
        // R8
        parity_pin_chk: assert (P0_AT_LSB ? (code_o[0] == overall_o)
                                          : (code_o[W-1] == overall_o));
        // R9
        zero_word_chk: assert ((data_i != '0) || (code_o == '0));
    end

    // Each data bit must reach its position in the packed word.
    for (genvar b = 0; b < K; b++) begin : g_dchk
        localparam int POS = secded_pkg::data_pos(b);
        localparam int BIT = P0_AT_LSB ? POS : POS - 1;
        always_comb begin
            // R3
            data_place_chk: assert (code_o[BIT] == data_i[b]);
        end
    end

endmodule

// File: tb/test_secded_encoder.sv
module test_secded_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int K = 8;
    localparam int M = 4;
    localparam int N = K + M;
    localparam int W = N + 1;

    typedef struct packed {
        logic [K-1:0] d;
        logic [M-1:0] c;
        logic         p;
    } vec_t;

    // Data, expected check bits (c3..c0), expected overall parity.
    localparam vec_t TABLE [10] = '{
        '{8'h00, 4'b0000, 1'b0},
        '{8'hFF, 4'b0011, 1'b0},
        '{8'h01, 4'b0011, 1'b1},
        '{8'h80, 4'b1100, 1'b1},
        '{8'h0F, 4'b0111, 1'b1},
        '{8'hF0, 4'b0100, 1'b1},
        '{8'hAA, 4'b0100, 1'b1},
        '{8'h55, 4'b0111, 1'b1},
        '{8'h10, 4'b1001, 1'b1},
        '{8'h3C, 4'b0010, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [K-1:0] data;
    logic [W-1:0] code_m, code_l;
    logic [M-1:0] chk_m, chk_l;
    logic         ov_m, ov_l;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secded_encoder #(.K(K), .P0_AT_LSB(1'b0)) i_secded_encoder (
        .data_i(data), .code_o(code_m), .check_o(chk_m), .overall_o(ov_m));
    secded_encoder #(.K(K), .P0_AT_LSB(1'b1)) i_secded_encoder_lsb (
        .data_i(data), .code_o(code_l), .check_o(chk_l), .overall_o(ov_l));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Hamming position of data bit b (R3).
    function automatic int dpos(input int b);
        int pos = 0;
        int cnt = -1;
        while (cnt < b) begin
            pos++;
            if ((pos & (pos - 1)) != 0) cnt++;
        end
        return pos;
    endfunction

    // Expected packed word from data, checks, parity (R3, R4, R6, R7).
    function automatic logic [W-1:0] mk_code(input logic [K-1:0] d, input logic [M-1:0] c,
                                             input logic p, input bit lsb);
        logic [N:0] h = '0;
        for (int b = 0; b < K; b++) h[dpos(b)] = d[b];
        for (int j = 0; j < M; j++) h[1 << j] = c[j];
        if (lsb) return {h[N:1], p};
        return {p, h[N:1]};
    endfunction

    // Check bits by definition (R2).
    function automatic logic [M-1:0] ref_chk(input logic [K-1:0] d);
        logic [M-1:0] c = '0;
        for (int b = 0; b < K; b++)
            for (int j = 0; j < M; j++)
                if ((dpos(b) >> j) & 1) c[j] ^= d[b];
        return c;
    endfunction

    task automatic apply(input logic [K-1:0] d);
        @(posedge clk);
        data = d;
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        data = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R9: zero data gives an all-zero word
        check(code_m == '0 && chk_m == '0 && !ov_m, "R9 msb", code_m, 0);
        check(code_l == '0 && chk_l == '0 && !ov_l, "R9 lsb", code_l, 0);
        // R1: widths
        check($bits(chk_m) == 4 && $bits(code_m) == 13, "R1 widths", $bits(code_m), 13);

        // Table walk: R2, R5, R6, R7, R8
        for (int t = 0; t < 10; t++) begin
            apply(TABLE[t].d);
            check(chk_m == TABLE[t].c, "R2 check", chk_m, TABLE[t].c);
            check(ov_m == TABLE[t].p, "R5 parity", ov_m, TABLE[t].p);
            check(code_m == mk_code(TABLE[t].d, TABLE[t].c, TABLE[t].p, 1'b0), "R6 msb word",
                  code_m, mk_code(TABLE[t].d, TABLE[t].c, TABLE[t].p, 1'b0));
            check(code_l == mk_code(TABLE[t].d, TABLE[t].c, TABLE[t].p, 1'b1), "R7 lsb word",
                  code_l, mk_code(TABLE[t].d, TABLE[t].c, TABLE[t].p, 1'b1));
            check(chk_l == chk_m && ov_l == ov_m, "R8 variants agree", {chk_l, ov_l}, {chk_m, ov_m});
        end

        // Directed: known words (R4, R6, R7)
        apply(8'h01);
        check(code_m == 13'h1007, "R4 R6 d0 msb", code_m, 13'h1007);
        check(code_l == 13'h000F, "R4 R7 d0 lsb", code_l, 13'h000F);
        apply(8'hFF);
        check(code_m == 13'h0F77, "R6 ones msb", code_m, 13'h0F77);
        // R3: top data bit reaches position 12
        apply(8'h80);
        check(code_m[11] == 1'b1 && code_l[12] == 1'b1, "R3 d7 pos12", code_m, 0);

        // Sweep all words: R2, R5, R8
        for (int v = 0; v < 256; v++) begin
            apply(v[K-1:0]);
            check(chk_m == ref_chk(v[K-1:0]), "R2 sweep", chk_m, ref_chk(v[K-1:0]));
            check((^code_m) == 1'b0 && (^code_l) == 1'b0, "R5 sweep", code_m, 0);
            check(code_m[W-1] == ov_m && code_l[0] == ov_l, "R8 sweep", {code_m[W-1], code_l[0]}, {ov_m, ov_l});
        end

        // R10: outputs follow data between clock edges
        @(negedge clk);
        data = 8'h10;
        #1;
        check(chk_m == 4'b1001, "R10 no clock", chk_m, 4'b1001);
        data = 8'h00;
        #1;
        check(code_m == '0, "R10 back to zero", code_m, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule